// File: doc/BRIEF.md
# Framed Serial Block Transmitter

This block streams a contiguous run of words out of a data memory to an external logger. It uses three lines: a serial clock, a serial data line and a frame strobe. An optional ready input lets the receiver pace the stream. Software places a start address and a word count on the block's inputs.

A transfer is armed by the slow tick that falls one tick period ahead of a compute pass. That pass then begins on a later tick. The stream may run past the start of the pass, and it finishes without a break. The block latches the address and the count at launch, so changes to them during a transfer have no effect on it.

The base clock `clk` runs at twice the faster serial rate. The serial clock is either half or a quarter of `clk`. It can run all the time, or it can be gated so that it runs only around a transfer.

Top module: `sblk_tx`

## Requirements
- R1: A transfer is launched only by a `slow_tick` pulse seen while `pass_next` is high, `en` is high, `blk_len` is nonzero and no transfer is in progress. A `slow_tick` with `pass_next` low starts nothing.
- R2: A transfer sends `blk_len` words. They come from consecutive addresses starting at `base_addr`, and the address wraps modulo 2^AW. Each word has DW bits and is sent most significant bit first, one bit per serial clock cycle.
- R3: `frame` is high for exactly one serial clock cycle, directly before the first bit of each word. `sdata` is low during that cycle. There is one frame per word.
- R4: `sdata` and `frame` change only on falling edges of `sclk`. They are stable while `sclk` is high.
- R5: With `full_rate`=1 the serial clock toggles on every `clk` cycle, which is `clk`/2. With `full_rate`=0 it toggles every second cycle, which is `clk`/4.
- R6: With `ckgate`=1, `sclk` is low while idle. It gives exactly three rising edges before the first frame, and exactly three rising edges after the last data bit, then stops low.
- R7: With `ckgate`=0 and `en`=1, `sclk` runs continuously, whether or not a transfer is in progress.
- R8: Once launched, a transfer completes using the address and length latched at launch. Later ticks and changes to `base_addr` or `blk_len` do not alter or stop it.
- R9: With `hs_en`=1, a word is framed only if `ready` is high at the falling `sclk` edge that would begin it. While the block waits, `sclk` keeps running and `frame` stays low.
- R10: A launch with `blk_len`=0 produces no frame, no memory read and no gated clock activity.
- R11: With `en`=0, `sclk`, `sdata` and `frame` are low and no transfer starts.
- R12: Each word is fetched by one single-cycle `mem_rd_en` strobe, with `mem_addr` holding the word's address. The memory must present the data on `mem_rdata` from the cycle after the strobe until the next strobe.
- R13: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock, twice the faster serial rate |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Interface enable |
| full_rate | input | 1 | 1: sclk = clk/2, 0: sclk = clk/4 |
| ckgate | input | 1 | 1: sclk runs only around a transfer |
| hs_en | input | 1 | Use `ready` to pace words |
| ready | input | 1 | Receiver ready for the next word |
| base_addr | input | AW | First word address of the block |
| blk_len | input | LW | Number of words in the block |
| slow_tick | input | 1 | One-cycle pulse per slow tick period |
| pass_next | input | 1 | High when the next tick begins a compute pass |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Memory read data |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| frame | output | 1 | Word frame strobe |

## Verification
The embedded properties assume that `en`, `full_rate` and `hs_en` are held steady around a transfer. They also assume that the memory answers a strobe on the next clock and keeps its data until the next strobe. The bench therefore sets the mode inputs and lets them settle for several cycles before each launch. Its memory model is a registered function of the address, read only on a strobe. Base address, length and tick are the only inputs the bench changes while a transfer runs, since those are the inputs the block must ignore once it is busy.

// File: rtl/sblk_tx.sv
module sblk_tx #(
  parameter int DW = 32,
  parameter int AW = 10,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          full_rate,
  input  logic          ckgate,
  input  logic          hs_en,
  input  logic          ready,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] blk_len,
  input  logic          slow_tick,
  input  logic          pass_next,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          sclk,
  output logic          sdata,
  output logic          frame
);
  localparam int BW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_WAIT, S_FRAME, S_BIT, S_POST} st_t;

  st_t           st;
  logic          div_q, sclk_q, pend, rd_q;
  logic [1:0]    cyc_q;
  logic [BW-1:0] bit_q;
  logic [LW-1:0] left_q;
  logic [AW-1:0] addr_q, maddr_q;
  logic [DW-1:0] shift_q;

  wire step   = en && (full_rate || div_q);
  wire fall   = step && sclk_q;
  wire launch = en && slow_tick && pass_next && (blk_len != '0) && (st == S_IDLE) && !pend;
  wire hold   = hs_en && !ready;

  assign sclk      = sclk_q && (!ckgate || st != S_IDLE);
  assign sdata     = (st == S_BIT) && shift_q[DW-1];
  assign frame     = (st == S_FRAME);
  assign mem_rd_en = rd_q;
  assign mem_addr  = maddr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= 1'b0;
      sclk_q  <= 1'b0;
      pend    <= 1'b0;
      rd_q    <= 1'b0;
      st      <= S_IDLE;
      cyc_q   <= '0;
      bit_q   <= '0;
      left_q  <= '0;
      addr_q  <= '0;
      maddr_q <= '0;
      shift_q <= '0;
    end else if (!en) begin
      div_q  <= 1'b0;
      sclk_q <= 1'b0;
      pend   <= 1'b0;
      rd_q   <= 1'b0;
      st     <= S_IDLE;
    end else begin
      div_q <= ~div_q;
      rd_q  <= 1'b0;
      if (step) sclk_q <= ~sclk_q;
      if (launch) begin
        pend   <= 1'b1;
        addr_q <= base_addr;
        left_q <= blk_len;
      end
      if (fall) begin
        case (st)
          S_IDLE: if (pend) begin
            st    <= S_PRE;
            cyc_q <= '0;
            pend  <= 1'b0;
          end
          S_PRE, S_WAIT: begin
            if (st == S_PRE && cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
            else if (hold) st <= S_WAIT;
            else begin
              st      <= S_FRAME;
              rd_q    <= 1'b1;
              maddr_q <= addr_q;
              addr_q  <= addr_q + AW'(1);
            end
          end
          S_FRAME: begin
            st      <= S_BIT;
            shift_q <= mem_rdata;
            bit_q   <= '0;
          end
          S_BIT: begin
            shift_q <= shift_q << 1;
            bit_q   <= bit_q + BW'(1);
            if (bit_q == BW'(DW - 1)) begin
              left_q <= left_q - LW'(1);
              if (left_q == LW'(1)) begin
                st    <= S_POST;
                cyc_q <= '0;
              end else if (hold) st <= S_WAIT;
              else begin
                st      <= S_FRAME;
                rd_q    <= 1'b1;
                maddr_q <= addr_q;
                addr_q  <= addr_q + AW'(1);
              end
            end
          end
          S_POST: begin
            if (cyc_q == 2'd2) st <= S_IDLE;
            else cyc_q <= cyc_q + 2'd1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R12
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$fell(sclk_q)) |-> ($stable(sdata) && $stable(frame))); // R4
  AST_FRAME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame |-> !sdata); // R3
  AST_FRAME_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame) && hs_en) |-> $past(ready)); // R9
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && full_rate && $past(full_rate)) |-> (sclk_q != $past(sclk_q))); // R5
  AST_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sclk && !frame && !sdata)); // R11
endmodule

// File: tb/sblk_tx_bench.sv
module sblk_tx_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, en = 1'b0, full_rate = 1'b1, ckgate = 1'b1, hs_en = 1'b0, ready = 1'b1;
  logic [9:0]  base_addr = '0;
  logic [7:0]  blk_len = '0;
  logic        slow_tick = 1'b0, pass_next = 1'b0;
  logic        mem_rd_en, sclk, sdata, frame;
  logic [9:0]  mem_addr;
  logic [31:0] mem_rdata = '0;

  sblk_tx u_sblk_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .full_rate(full_rate), .ckgate(ckgate),
    .hs_en(hs_en), .ready(ready), .base_addr(base_addr), .blk_len(blk_len),
    .slow_tick(slow_tick), .pass_next(pass_next), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .sclk(sclk), .sdata(sdata), .frame(frame)
  );

  function automatic logic [31:0] memw(input logic [9:0] a);
    return 32'h9E3779B9 * ({22'd0, a} + 32'd1);
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= memw(mem_addr);

  // Monitor: samples at the falling edge of clk, away from the active edge
  logic        mon_clr = 1'b0;
  logic        sclk_p = 1'b0, sdata_p = 1'b0, frame_p = 1'b0, word_open = 1'b0;
  logic [31:0] shreg = '0;
  logic [31:0] rx [0:7];
  int rises = 0, rx_cnt = 0, pre_r = 0, post_r = 0, frm_cnt = 0, rd_cnt = 0, bits = 0, r4_bad = 0;

  always @(negedge clk) begin
    if (mon_clr) begin
      rises = 0; rx_cnt = 0; pre_r = 0; post_r = 0; frm_cnt = 0; rd_cnt = 0;
      bits = 0; r4_bad = 0; word_open = 1'b0;
    end else begin
      if (mem_rd_en) rd_cnt++;
      if (sclk_p && sclk && (sdata != sdata_p || frame != frame_p)) r4_bad++;
      if (sclk && !sclk_p) begin
        rises++;
        if (frame) begin
          frm_cnt++; word_open = 1'b1; bits = 0;
        end else if (word_open) begin
          shreg = {shreg[30:0], sdata};
          bits++;
          if (bits == 32) begin
            rx[rx_cnt[2:0]] = shreg; rx_cnt++; word_open = 1'b0; post_r = 0;
          end
        end else if (rx_cnt == 0) pre_r++;
        else post_r++;
      end
    end
    sclk_p = sclk; sdata_p = sdata; frame_p = frame;
  end

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_mon();
    mon_clr = 1'b1; cyc(1); mon_clr = 1'b0;
  endtask

  task automatic fire(input logic pn);
    pass_next = pn; slow_tick = 1'b1; cyc(1);
    slow_tick = 1'b0; pass_next = 1'b0;
  endtask

  task automatic wait_words(input int n);
    for (int i = 0; i < 6000 && rx_cnt < n; i++) cyc(1);
    cyc(80);
  endtask

  // {base[9:0], len[7:0], full_rate, ckgate, hs_en}
  localparam logic [20:0] VEC [0:5] = '{
    {10'd5,    8'd3, 3'b110},
    {10'd100,  8'd1, 3'b010},
    {10'd1021, 8'd4, 3'b110},
    {10'd200,  8'd2, 3'b100},
    {10'd7,    8'd2, 3'b011},
    {10'd500,  8'd5, 3'b001}
  };

  initial begin
    cyc(4);
    // R13: reset state
    chk(!sclk && !sdata && !frame && !mem_rd_en, "R13", {sclk, sdata, frame, mem_rd_en}, 0);
    rst_n = 1'b1; cyc(2);
    chk(!sclk && !sdata && !frame && !mem_rd_en, "R13", {sclk, sdata, frame, mem_rd_en}, 0);

    // R11: disabled block ignores launch and keeps clock low
    ckgate = 1'b0; base_addr = 10'd3; blk_len = 8'd2; clear_mon(); fire(1'b1); cyc(200);
    chk(rises == 0 && frm_cnt == 0, "R11", rises + frm_cnt, 0);

    // R5 / R7: continuous clock rates
    en = 1'b1; full_rate = 1'b1; cyc(8); clear_mon(); cyc(40);
    chk(rises == 20, "R5 R7 full", rises, 20);
    full_rate = 1'b0; cyc(8); clear_mon(); cyc(40);
    chk(rises == 10, "R5 R7 half", rises, 10);

    // R1: tick without pass_next starts nothing
    ckgate = 1'b1; full_rate = 1'b1; cyc(8); clear_mon(); fire(1'b0); cyc(300);
    chk(rises == 0 && frm_cnt == 0, "R1", rises + frm_cnt, 0);

    // R10: zero length
    blk_len = 8'd0; clear_mon(); fire(1'b1); cyc(300);
    chk(rises == 0 && frm_cnt == 0 && rd_cnt == 0, "R10", rises + frm_cnt + rd_cnt, 0);

    // Vector walk: R1 R2 R3 R4 R6 R8 R12
    foreach (VEC[v]) begin
      logic [9:0] b;
      int l;
      b = VEC[v][20:11]; l = int'(VEC[v][10:3]);
      full_rate = VEC[v][2]; ckgate = VEC[v][1]; hs_en = VEC[v][0]; ready = 1'b1;
      base_addr = b; blk_len = 8'(l); cyc(10); clear_mon();
      fire(1'b1);
      cyc(30);
      base_addr = 10'd0; blk_len = 8'd0; fire(1'b0);  // R8: pass begins, registers change
      wait_words(l);
      chk(rx_cnt == l, "R1 R8 word count", rx_cnt, l);
      for (int k = 0; k < l; k++)
        chk(rx[k] == memw(b + 10'(k)), "R2 word", int'(rx[k]), int'(memw(b + 10'(k))));
      chk(frm_cnt == l, "R3 frames", frm_cnt, l);
      chk(rd_cnt == l, "R12 reads", rd_cnt, l);
      chk(r4_bad == 0, "R4 data while sclk high", r4_bad, 0);
      if (ckgate) begin
        chk(pre_r == 3, "R6 lead", pre_r, 3);
        chk(post_r == 3, "R6 trail", post_r, 3);
        chk(!sclk, "R6 idle low", sclk, 0);
      end
    end

    // R9: handshake holds framing until ready
    full_rate = 1'b1; ckgate = 1'b1; hs_en = 1'b1; ready = 1'b0;
    base_addr = 10'd50; blk_len = 8'd2; cyc(10); clear_mon(); fire(1'b1); cyc(300);
    chk(frm_cnt == 0, "R9 held", frm_cnt, 0);
    chk(rises > 3, "R9 clock runs while waiting", rises, 4);
    ready = 1'b1; wait_words(2);
    chk(rx_cnt == 2, "R9 released", rx_cnt, 2);
    chk(rx[0] == memw(10'd50) && rx[1] == memw(10'd51), "R9 data", int'(rx[0]), int'(memw(10'd50)));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule